// File: doc/BRIEF.md
# Retained Register Bank with Movable Secure Fence

This block holds a small set of 32-bit words that must persist across ordinary resets. Typical uses are boot-stage handoff values, wake-up addresses and counters that one software stage leaves for the next. Each word sits on a plain request/response port. Every request carries an attribute that marks it as either trusted (secure) or untrusted (non-secure).

A fence index divides the bank in two. Words whose index is below the fence answer only trusted requests. Words at or above the fence answer both kinds. The fence itself appears as one more word, located just past the last data word. Anyone may read it, but only a trusted write can move it.

A rejected request has no effect on any stored state. It reads back as zero, and its response carries an error flag. The stored words are cleared only by the power-on reset. The soft reset puts the fence back to its default position and leaves the words as they were.

Top module: `keepreg_bank`

## Requirements
- R1: While either reset is asserted, and after reset, `rsp_valid` is low and `req_ready` is low. `req_ready` rises within a few cycles of release, and the fence then reads 10.
- R2: A secure request may read or write any data word. Word n is at byte offset 4*n, for n from 0 to 31. A read returns the last value written. A write response carries zero data.
- R3: A non-secure request whose word index is at or above the fence reads and writes that word normally, with no error.
- R4: A non-secure read of a word whose index is below the fence returns zero, and its response has `rsp_err` high.
- R5: A non-secure write to a word whose index is below the fence leaves the word unchanged, and its response has `rsp_err` high.
- R6: The fence is at byte offset 0x80, and its value sits in the low bits of the read data. Any request may read it. A secure write sets it. A non-secure write leaves it unchanged and raises `rsp_err`.
- R7: A written fence value above 32 is stored as 32, which makes every word secure. A fence of 0 opens every word to non-secure requests.
- R8: An address whose low two bits are not zero, or whose byte offset is above 0x80, returns zero data and raises `rsp_err`, whatever the request's attribute. A write to such an address changes nothing.
- R9: A soft reset (`rst_n`) returns the fence to 10 and keeps every data word. A power-on reset (`por_n`) clears every data word to zero and also returns the fence to 10.
- R10: `rsp_valid` is high for exactly the one cycle after each accepted request (`req_valid` and `req_ready` both high) and is low otherwise. `rsp_err` is never high without `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft reset, active low. Resets the fence and control logic. |
| por_n | input | 1 | Power-on reset, active low. Also clears the stored words. |
| req_valid | input | 1 | A request is present |
| req_ready | output | 1 | The bank accepts requests |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = trusted request |
| req_addr | input | 8 | Byte offset inside the bank |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_err | output | 1 | The request was rejected |
| rsp_rdata | output | 32 | Read data. Zero on writes and on rejected requests. |

## Verification
A wrong fence value shows up at the ports on the first access that lands between the true and the corrupted fence. Such a non-secure request gets the wrong verdict in its response, one cycle after acceptance, and a read of offset 0x80 exposes the fence directly in that same cycle. A word corrupted by a write that should have been dropped stays hidden until the next secure read of that word, so the tests read each guarded word back right after an attempt to overwrite it. A reset that clears too much or too little shows on the first read after release.

// File: rtl/kb_pkg.sv
package kb_pkg;
  localparam int unsigned KB_NREG      = 32;
  localparam int unsigned KB_DW        = 32;
  localparam int unsigned KB_AW        = 8;
  localparam int unsigned KB_FENCE_RST = 10;
  localparam int unsigned KB_SYNC_STG  = 2;

  typedef enum logic [1:0] {
    KB_HIT_REG   = 2'd0,
    KB_HIT_FENCE = 2'd1,
    KB_HIT_NONE  = 2'd2
  } kb_hit_e;
endpackage

// File: rtl/kb_rst_sync.sv
module kb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n_in,
  output logic arst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n_in) begin
    if (!arst_n_in) sync_q <= '0;
    else            sync_q <= sync_d;
  end

  assign arst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/kb_gate.sv
module kb_gate
  import kb_pkg::*;
#(
  parameter int unsigned NREG   = KB_NREG,
  parameter int unsigned WIDX_W = 6,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned SLOT_W = 5
) (
  input  logic [WIDX_W-1:0] widx,
  input  logic              aligned,
  input  logic [IDX_W-1:0]  fence,
  input  logic              is_write,
  input  logic              is_secure,
  output kb_hit_e           hit,
  output logic              allow,
  output logic [SLOT_W-1:0] slot
);
  localparam int unsigned CW = (WIDX_W > IDX_W ? WIDX_W : IDX_W) + 1;
  localparam logic [CW-1:0] NREG_C = CW'(NREG);

  logic [CW-1:0] widx_c;
  logic [CW-1:0] fence_c;

  always_comb begin
    widx_c  = CW'(widx);
    fence_c = CW'(fence);
    slot    = widx[SLOT_W-1:0];
    hit     = KB_HIT_NONE;
    allow   = 1'b0;
    if (aligned) begin
      if (widx_c < NREG_C) begin
        hit   = KB_HIT_REG;
        allow = is_secure || (widx_c >= fence_c);
      end else if (widx_c == NREG_C) begin
        hit   = KB_HIT_FENCE;
        allow = !is_write || is_secure;
      end
    end
  end
endmodule

// File: rtl/kb_fence.sv
module kb_fence #(
  parameter int unsigned NREG    = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned RST_VAL = 10
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic [IDX_W-1:0] fence
);
  localparam logic [DW-1:0]    TOP_DW  = DW'(NREG);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG);
  localparam logic [IDX_W-1:0] RST_IDX = IDX_W'(RST_VAL);

  logic [IDX_W-1:0] fence_q;
  logic [IDX_W-1:0] fence_d;

  always_comb begin
    fence_d = fence_q;
    if (wr_en) begin
      if (wdata > TOP_DW) fence_d = TOP_IDX;
      else                fence_d = wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) fence_q <= RST_IDX;
    else         fence_q <= fence_d;
  end

  assign fence = fence_q;
endmodule

// File: rtl/kb_store.sv
module kb_store #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DW-1:0]     wdata,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] bank_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_word
    logic          hit_en;
    logic [DW-1:0] word_d;

    always_comb begin
      hit_en = wr_en && (wr_slot == SLOT_W'(g));
      word_d = hit_en ? wdata : bank_q[g];
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) bank_q[g] <= '0;
      else         bank_q[g] <= word_d;
    end
  end

  assign rd_data = bank_q[rd_slot];
endmodule

// File: rtl/keepreg_bank.sv
module keepreg_bank
  import kb_pkg::*;
#(
  parameter int unsigned NREG      = KB_NREG,
  parameter int unsigned DW        = KB_DW,
  parameter int unsigned AW        = KB_AW,
  parameter int unsigned FENCE_RST = KB_FENCE_RST,
  parameter int unsigned SYNC_STG  = KB_SYNC_STG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_secure,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);
  localparam int unsigned WIDX_W = AW - 2;
  localparam int unsigned IDX_W  = $clog2(NREG + 1);
  localparam int unsigned SLOT_W = $clog2(NREG);

  logic ctl_arst_n;
  logic mem_arst_n;
  logic rst_comb_n;

  assign rst_comb_n = rst_n & por_n;

  kb_rst_sync #(.STAGES(SYNC_STG)) u_ctl_sync (
    .clk(clk), .arst_n_in(rst_comb_n), .arst_n_out(ctl_arst_n)
  );
  kb_rst_sync #(.STAGES(SYNC_STG)) u_mem_sync (
    .clk(clk), .arst_n_in(por_n), .arst_n_out(mem_arst_n)
  );

  // request acceptance
  logic ready_q;
  logic acc;

  always_ff @(posedge clk or negedge ctl_arst_n) begin
    if (!ctl_arst_n) ready_q <= 1'b0;
    else             ready_q <= 1'b1;
  end

  assign req_ready = ready_q;
  assign acc       = req_valid & ready_q;

  // decode and permission
  logic [IDX_W-1:0]  fence;
  kb_hit_e           hit;
  logic              allow;
  logic [SLOT_W-1:0] slot;
  logic              aligned;

  assign aligned = (req_addr[1:0] == 2'b00);

  kb_gate #(
    .NREG(NREG), .WIDX_W(WIDX_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_gate (
    .widx(req_addr[AW-1:2]), .aligned(aligned), .fence(fence),
    .is_write(req_write), .is_secure(req_secure),
    .hit(hit), .allow(allow), .slot(slot)
  );

  // storage and fence
  logic          store_we;
  logic          fence_we;
  logic [DW-1:0] store_rd;

  always_comb begin
    store_we = acc && req_write && allow && (hit == KB_HIT_REG);
    fence_we = acc && req_write && allow && (hit == KB_HIT_FENCE);
  end

  kb_store #(.NREG(NREG), .DW(DW), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .arst_n(mem_arst_n), .wr_en(store_we), .wr_slot(slot),
    .wdata(req_wdata), .rd_slot(slot), .rd_data(store_rd)
  );

  kb_fence #(
    .NREG(NREG), .DW(DW), .IDX_W(IDX_W), .RST_VAL(FENCE_RST)
  ) u_fence (
    .clk(clk), .arst_n(ctl_arst_n), .wr_en(fence_we),
    .wdata(req_wdata), .fence(fence)
  );

  // response
  logic          rsp_valid_q, rsp_valid_d;
  logic          rsp_err_q,   rsp_err_d;
  logic [DW-1:0] rsp_rdata_q, rsp_rdata_d;

  always_comb begin
    rsp_valid_d = acc;
    rsp_err_d   = acc && !allow;
    rsp_rdata_d = '0;
    if (acc && !req_write && allow) begin
      if (hit == KB_HIT_FENCE) rsp_rdata_d = DW'(fence);
      else                     rsp_rdata_d = store_rd;
    end
  end

  always_ff @(posedge clk or negedge ctl_arst_n) begin
    if (!ctl_arst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/kb_checker.sv
module kb_checker #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 8,
  parameter int unsigned IDX_W = 6
) (
  input logic             clk,
  input logic             arst_n,
  input logic             acc,
  input logic             is_write,
  input logic             is_secure,
  input logic [AW-1:0]    addr,
  input logic [IDX_W-1:0] fence,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [DW-1:0]    rsp_rdata
);
  localparam int unsigned WIDX_W = AW - 2;
  localparam int unsigned CW = (WIDX_W > IDX_W ? WIDX_W : IDX_W) + 1;
  localparam logic [CW-1:0] NREG_C = CW'(NREG);

  logic [CW-1:0] widx_c;
  logic [CW-1:0] fence_c;
  logic          aligned;

  assign widx_c  = CW'(addr[AW-1:2]);
  assign fence_c = CW'(fence);
  assign aligned = (addr[1:0] == 2'b00);

  assert_rsp_after_req_R10: assert property (@(posedge clk) disable iff (!arst_n)
    acc |=> rsp_valid);

  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!arst_n)
    !acc |=> !rsp_valid);

  assert_err_with_valid_R10: assert property (@(posedge clk) disable iff (!arst_n)
    rsp_err |-> rsp_valid);

  assert_fence_bounded_R7: assert property (@(posedge clk) disable iff (!arst_n)
    fence_c <= NREG_C);

  assert_ns_low_read_blocked_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (acc && !is_write && !is_secure && aligned && widx_c < fence_c)
    |=> (rsp_err && rsp_rdata == '0));

  assert_ns_fence_write_kept_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (acc && is_write && !is_secure && aligned && widx_c == NREG_C)
    |=> ($stable(fence) && rsp_err));

  assert_stray_addr_err_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (acc && (!aligned || widx_c > NREG_C))
    |=> (rsp_err && rsp_rdata == '0));
endmodule

bind keepreg_bank kb_checker #(
  .NREG(NREG), .DW(DW), .AW(AW), .IDX_W(IDX_W)
) u_kb_checker (
  .clk(clk), .arst_n(ctl_arst_n), .acc(acc), .is_write(req_write),
  .is_secure(req_secure), .addr(req_addr), .fence(fence),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/keepreg_bank_tb.sv
module keepreg_bank_tb_top;
  logic        clk;
  logic        rst_n;
  logic        por_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic        req_secure;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;

  int n_run  = 0;
  int n_fail = 0;

  keepreg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  typedef struct packed {
    logic        wr;
    logic        sec;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic        exp_err;
    logic [3:0]  rq;
  } vec_t;

  localparam int NVEC = 26;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 8'h00, 32'hA0A0_0001, 32'h0,         1'b0, 4'd2},  // R2
    '{1'b0, 1'b1, 8'h00, 32'h0,         32'hA0A0_0001, 1'b0, 4'd2},  // R2
    '{1'b0, 1'b0, 8'h00, 32'h0,         32'h0,         1'b1, 4'd4},  // R4
    '{1'b1, 1'b0, 8'h00, 32'h0000_FFFF, 32'h0,         1'b1, 4'd5},  // R5
    '{1'b0, 1'b1, 8'h00, 32'h0,         32'hA0A0_0001, 1'b0, 4'd5},  // R5
    '{1'b1, 1'b0, 8'h28, 32'h1234_5678, 32'h0,         1'b0, 4'd3},  // R3
    '{1'b0, 1'b0, 8'h28, 32'h0,         32'h1234_5678, 1'b0, 4'd3},  // R3
    '{1'b1, 1'b0, 8'h24, 32'h0000_5555, 32'h0,         1'b1, 4'd5},  // R5
    '{1'b0, 1'b1, 8'h24, 32'h0,         32'h0,         1'b0, 4'd5},  // R5
    '{1'b0, 1'b0, 8'h80, 32'h0,         32'd10,        1'b0, 4'd6},  // R6
    '{1'b1, 1'b0, 8'h80, 32'h0,         32'h0,         1'b1, 4'd6},  // R6
    '{1'b0, 1'b0, 8'h80, 32'h0,         32'd10,        1'b0, 4'd6},  // R6
    '{1'b1, 1'b1, 8'h80, 32'd12,        32'h0,         1'b0, 4'd6},  // R6
    '{1'b0, 1'b0, 8'h28, 32'h0,         32'h0,         1'b1, 4'd4},  // R4
    '{1'b1, 1'b1, 8'h7C, 32'hDEAD_BEEF, 32'h0,         1'b0, 4'd2},  // R2
    '{1'b0, 1'b1, 8'h7C, 32'h0,         32'hDEAD_BEEF, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b1, 8'h80, 32'd100,       32'h0,         1'b0, 4'd7},  // R7
    '{1'b0, 1'b1, 8'h80, 32'h0,         32'd32,        1'b0, 4'd7},  // R7
    '{1'b0, 1'b0, 8'h7C, 32'h0,         32'h0,         1'b1, 4'd7},  // R7
    '{1'b1, 1'b1, 8'h84, 32'h1,         32'h0,         1'b1, 4'd8},  // R8
    '{1'b0, 1'b1, 8'h84, 32'h0,         32'h0,         1'b1, 4'd8},  // R8
    '{1'b0, 1'b0, 8'hFC, 32'h0,         32'h0,         1'b1, 4'd8},  // R8
    '{1'b0, 1'b1, 8'h7E, 32'h0,         32'h0,         1'b1, 4'd8},  // R8
    '{1'b1, 1'b1, 8'h80, 32'd0,         32'h0,         1'b0, 4'd7},  // R7
    '{1'b0, 1'b0, 8'h00, 32'h0,         32'hA0A0_0001, 1'b0, 4'd7},  // R7
    '{1'b1, 1'b0, 8'h04, 32'h0BAD_F00D, 32'h0,         1'b0, 4'd7}   // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic sec, input logic [7:0] addr,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output logic err, output logic vld);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_secure = sec;
    req_addr   = addr;
    req_wdata  = wd;
    @(negedge clk);
    vld       = rsp_valid;
    rd        = rsp_rdata;
    err       = rsp_err;
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic pulse(input bit use_por);
    @(negedge clk);
    if (use_por) por_n = 1'b0; else rst_n = 1'b0;
    repeat (3) @(negedge clk);
    if (use_por) por_n = 1'b1; else rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        err;
    logic        vld;

    rst_n = 1'b0; por_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", 32'(req_ready), 32'd0);
    chk("R1 rsp_valid low in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 ready after release", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
    xfer(1'b0, 1'b0, 8'h80, 32'h0, rd, err, vld);
    chk("R1 default fence", rd, 32'd10);

    for (int i = 0; i < NVEC; i++) begin
      xfer(VECS[i].wr, VECS[i].sec, VECS[i].addr, VECS[i].wd, rd, err, vld);
      chk($sformatf("R%0d vec%0d valid", VECS[i].rq, i), 32'(vld), 32'd1);
      chk($sformatf("R%0d vec%0d data", VECS[i].rq, i), rd, VECS[i].exp_rd);
      chk($sformatf("R%0d vec%0d err", VECS[i].rq, i), 32'(err), 32'(VECS[i].exp_err));
    end

    // R10: no response in an idle cycle
    @(negedge clk);
    chk("R10 idle valid", 32'(rsp_valid), 32'd0);
    chk("R10 idle err", 32'(rsp_err), 32'd0);

    // R9: soft reset keeps words, restores fence
    pulse(1'b0);
    xfer(1'b0, 1'b0, 8'h80, 32'h0, rd, err, vld);
    chk("R9 fence after soft reset", rd, 32'd10);
    xfer(1'b0, 1'b1, 8'h00, 32'h0, rd, err, vld);
    chk("R9 word0 kept", rd, 32'hA0A0_0001);
    xfer(1'b0, 1'b1, 8'h04, 32'h0, rd, err, vld);
    chk("R9 word1 kept", rd, 32'h0BAD_F00D);

    // R9: power-on reset clears words
    pulse(1'b1);
    xfer(1'b0, 1'b1, 8'h00, 32'h0, rd, err, vld);
    chk("R9 word0 cleared", rd, 32'h0);
    xfer(1'b0, 1'b1, 8'h7C, 32'h0, rd, err, vld);
    chk("R9 word31 cleared", rd, 32'h0);
    xfer(1'b0, 1'b1, 8'h80, 32'h0, rd, err, vld);
    chk("R9 fence after power-on", rd, 32'd10);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule